// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns a raw asynchronous serial line into received words. A baud tick from outside sets the sampling rate: sixteen ticks per bit in normal mode, eight per bit in fast mode. The receiver synchronises the line and waits for a low level. It confirms the start bit at mid-bit and votes three centre samples for every bit. It then assembles a frame of 5 to 9 data bits, least significant bit first. An optional parity bit and a stop bit follow the data bits.

Each finished frame goes into a small buffer. The buffer holds two entries by default and stores the word together with its own framing, parity and overrun flags. The consumer sees the oldest entry on the outputs while the receive-complete output is high, and a one-cycle read strobe removes that entry. In multi-processor mode, 9-bit frames whose ninth bit is clear are dropped, so a listener that waits for an address frame ignores traffic for other listeners.

Top module: `rxu_serial_rx`

## Requirements
- R1: `word_len` selects the data bit count. Values 5 to 9 are used as given, values below 5 act as 5 and values above 9 act as 9. Bits arrive least significant first. Bits of `rx_data` at or above the data bit count read 0, and `rx_bit9` shows the ninth data bit only for 9-bit frames (0 otherwise).
- R2: With `double_speed`=0 a bit lasts 16 ticks and its value is the majority of its samples 8, 9 and 10. With `double_speed`=1 a bit lasts 8 ticks and the majority of samples 4, 5 and 6 is used. One wrong sample among the three does not change the bit.
- R3: A low level that is not confirmed low by the start-bit majority returns the receiver to idle, and nothing is stored.
- R4: With `parity_en`=1 one parity bit follows the data bits. `parity_odd`=0 expects an even count of ones over the data and parity bits, and `parity_odd`=1 expects an odd count. A mismatch sets `err_parity` in that entry.
- R5: Only the first stop bit is checked. If it is sampled low, `err_frame` is set in that entry. A frame completes at the middle of its first stop bit, so frames sent back to back with two stop bits are all received.
- R6: Entries leave the buffer in arrival order. `rx_valid` is high while at least one entry is held. A high `rd_strobe` while `rx_valid` is high removes the entry on the outputs, and a read of an empty buffer has no effect. While the buffer is empty, all data and flag outputs read 0.
- R7: A frame that completes while the buffer is full, with no read in that cycle, is dropped. The newest held entry then gets `err_overrun`=1.
- R8: The framing, parity and overrun flags belong to a single entry and appear on the outputs together with that entry's data.
- R9: With `mp_mode`=1 and 9 data bits, a frame whose ninth bit is 0 is discarded and a frame whose ninth bit is 1 is stored. Frames with fewer data bits are stored as usual.
- R10: After reset the buffer is empty, `rx_valid` is 0 and all flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Raw serial line, idle high |
| baud_tick | input | 1 | One-cycle oversampling tick |
| double_speed | input | 1 | 1: eight samples per bit, 0: sixteen |
| word_len | input | 4 | Data bit count, 5 to 9 |
| parity_en | input | 1 | Parity bit present |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| mp_mode | input | 1 | Multi-processor address filter enable |
| rd_strobe | input | 1 | Remove the oldest entry |
| rx_data | output | 8 | Low eight data bits of the oldest entry |
| rx_bit9 | output | 1 | Ninth data bit of the oldest entry |
| err_frame | output | 1 | Framing error flag of the oldest entry |
| err_parity | output | 1 | Parity error flag of the oldest entry |
| err_overrun | output | 1 | Overrun flag of the oldest entry |
| rx_valid | output | 1 | Receive complete: buffer not empty |

## Verification
The assertions assume that `word_len` and `mp_mode` stay constant from start bit to stop bit. The address-filter property reads the live port values, while the receiver latches its format when the start bit arrives. They also assume that `baud_tick` is a single-cycle pulse, so one frame completion is one store attempt. The stimulus changes its format inputs only while the line is idle. It raises the tick for one cycle in every four, and it holds `rd_strobe` for exactly one cycle.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

    localparam int unsigned MAX_BITS = 9;
    localparam int unsigned MIN_BITS = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    // one buffered frame with its own flags
    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                fe;
        logic                pe;
        logic                dor;
    } rx_entry_t;

endpackage

// File: rtl/rxu_line_sync.sv
module rxu_line_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/rxu_frame_fsm.sv
module rxu_frame_fsm
    import rxu_pkg::*;
#(
    parameter int unsigned OS_NORM = 16,
    parameter int unsigned OS_FAST = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      line_s,
    input  logic      baud_tick,
    input  logic      double_speed,
    input  logic [3:0] len_eff,
    input  logic      parity_en,
    input  logic      parity_odd,
    input  logic      mp_mode,
    output logic      frame_done,
    output logic      frame_keep,
    output rx_entry_t frame_entry,
    output logic      busy
);

    localparam int unsigned CW    = $clog2(OS_NORM + 1);
    localparam int unsigned MID_N = OS_NORM / 2;
    localparam int unsigned MID_F = OS_FAST / 2;

    typedef struct packed {
        rx_state_e           st;
        logic [CW-1:0]       cnt;
        logic [1:0]          vote;
        logic [3:0]          len;
        logic [3:0]          idx;
        logic [MAX_BITS-1:0] sh;
        logic                par;
        logic                pe;
        logic                fast;
        logic                pen;
        logic                podd;
    } fsm_t;

    fsm_t q, d;

    logic [CW-1:0] os_lim, mid_c;
    logic          vote_now;

    always_comb begin
        d           = q;
        frame_done  = 1'b0;
        frame_keep  = 1'b0;
        frame_entry = '0;

        os_lim   = q.fast ? CW'(OS_FAST) : CW'(OS_NORM);
        mid_c    = q.fast ? CW'(MID_F)   : CW'(MID_N);
        vote_now = (q.vote[0] & q.vote[1]) | (q.vote[0] & line_s) | (q.vote[1] & line_s);

        if (baud_tick) begin
            if (q.st == ST_IDLE) begin
                if (!line_s) begin
                    d.st   = ST_START;
                    d.cnt  = CW'(1);
                    d.fast = double_speed;
                    d.len  = len_eff;
                    d.pen  = parity_en;
                    d.podd = parity_odd;
                    d.sh   = '0;
                    d.par  = 1'b0;
                    d.pe   = 1'b0;
                    d.idx  = '0;
                    d.vote = '0;
                end
            end else begin
                d.cnt = (q.cnt == os_lim) ? CW'(1) : q.cnt + CW'(1);
                if (q.cnt == mid_c)          d.vote[0] = line_s;
                if (q.cnt == mid_c + CW'(1)) d.vote[1] = line_s;
                if (q.cnt == mid_c + CW'(2)) begin
                    case (q.st)
                        ST_START: begin
                            d.st = vote_now ? ST_IDLE : ST_DATA;
                        end
                        ST_DATA: begin
                            d.sh[q.idx] = vote_now;
                            d.par       = q.par ^ vote_now;
                            if (q.idx == q.len - 4'd1) d.st = q.pen ? ST_PARITY : ST_STOP;
                            else                       d.idx = q.idx + 4'd1;
                        end
                        ST_PARITY: begin
                            d.pe = (vote_now != (q.par ^ q.podd));
                            d.st = ST_STOP;
                        end
                        ST_STOP: begin
                            frame_done       = 1'b1;
                            frame_keep       = !(mp_mode && q.len == 4'd9 && !q.sh[MAX_BITS-1]);
                            frame_entry.data = q.sh;
                            frame_entry.fe   = !vote_now;
                            frame_entry.pe   = q.pe;
                            frame_entry.dor  = 1'b0;
                            d.st             = ST_IDLE;
                        end
                        default: d.st = ST_IDLE;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != ST_IDLE);

endmodule

// File: rtl/rxu_rx_fifo.sv
module rxu_rx_fifo
    import rxu_pkg::*;
#(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  rx_entry_t     push_entry,
    input  logic          pop,
    output rx_entry_t     head,
    output logic [CW-1:0] count
);

    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]         wr;
        logic [PW-1:0]         rd;
        logic [CW-1:0]         cnt;
    } fifo_t;

    fifo_t q, d;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    function automatic logic [PW-1:0] ptr_dec(input logic [PW-1:0] p);
        return (p == '0) ? PW'(DEPTH - 1) : p - PW'(1);
    endfunction

    logic pop_ok, full, push_ok;

    always_comb begin
        d       = q;
        pop_ok  = pop && (q.cnt != '0);
        full    = (q.cnt == CW'(DEPTH));
        push_ok = push && (!full || pop_ok);

        if (push_ok) begin
            d.mem[q.wr] = push_entry;
            d.wr        = ptr_inc(q.wr);
        end else if (push) begin
            d.mem[ptr_dec(q.wr)].dor = 1'b1;
        end

        if (pop_ok) d.rd = ptr_inc(q.rd);

        case ({push_ok, pop_ok})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head  = (q.cnt != '0) ? q.mem[q.rd] : '0;
    assign count = q.cnt;

endmodule

// File: rtl/rxu_serial_rx.sv
module rxu_serial_rx
    import rxu_pkg::*;
#(
    parameter int unsigned OS_NORM     = 16,
    parameter int unsigned OS_FAST     = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DEPTH       = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_line,
    input  logic       baud_tick,
    input  logic       double_speed,
    input  logic [3:0] word_len,
    input  logic       parity_en,
    input  logic       parity_odd,
    input  logic       mp_mode,
    input  logic       rd_strobe,
    output logic [7:0] rx_data,
    output logic       rx_bit9,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_overrun,
    output logic       rx_valid
);

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic             line_s;
    logic [3:0]       len_eff;
    logic             frame_done, frame_keep, frame_bit9, busy, store;
    rx_entry_t        frame_entry, head;
    logic [CNT_W-1:0] fifo_count;

    always_comb begin
        if (word_len < 4'(MIN_BITS))      len_eff = 4'(MIN_BITS);
        else if (word_len > 4'(MAX_BITS)) len_eff = 4'(MAX_BITS);
        else                              len_eff = word_len;
    end

    rxu_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_s)
    );

    rxu_frame_fsm #(.OS_NORM(OS_NORM), .OS_FAST(OS_FAST)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_s      (line_s),
        .baud_tick   (baud_tick),
        .double_speed(double_speed),
        .len_eff     (len_eff),
        .parity_en   (parity_en),
        .parity_odd  (parity_odd),
        .mp_mode     (mp_mode),
        .frame_done  (frame_done),
        .frame_keep  (frame_keep),
        .frame_entry (frame_entry),
        .busy        (busy)
    );

    assign store      = frame_done & frame_keep;
    assign frame_bit9 = frame_entry.data[MAX_BITS-1];

    rxu_rx_fifo #(.DEPTH(DEPTH), .CW(CNT_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (store),
        .push_entry(frame_entry),
        .pop       (rd_strobe),
        .head      (head),
        .count     (fifo_count)
    );

    assign rx_data     = head.data[7:0];
    assign rx_bit9     = head.data[MAX_BITS-1];
    assign err_frame   = head.fe;
    assign err_parity  = head.pe;
    assign err_overrun = head.dor;
    assign rx_valid    = (fifo_count != '0);

endmodule

// File: rtl/rxu_serial_rx_chk.sv
module rxu_serial_rx_chk #(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned CW    = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_strobe,
    input logic          rx_valid,
    input logic          mp_mode,
    input logic [3:0]    word_len,
    input logic          store,
    input logic          frame_done,
    input logic          frame_bit9,
    input logic          busy,
    input logic [CW-1:0] fifo_count
);

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CW'(DEPTH));

    p_store_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        store |=> rx_valid);

    p_read_pops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rd_strobe && !store) |=> (fifo_count == CW'($past(fifo_count) - 1'b1)));

    p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && rd_strobe && !store) |=> !rx_valid);

    p_overrun_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (store && fifo_count == CW'(DEPTH) && !rd_strobe) |=> (fifo_count == CW'(DEPTH)));

    p_addr_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && mp_mode && word_len == 4'd9 && !frame_bit9 && fifo_count == '0 && !rd_strobe)
        |=> !rx_valid);

    p_done_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> busy);

endmodule

bind rxu_serial_rx rxu_serial_rx_chk #(.DEPTH(DEPTH), .CW(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_strobe (rd_strobe),
    .rx_valid  (rx_valid),
    .mp_mode   (mp_mode),
    .word_len  (word_len),
    .store     (store),
    .frame_done(frame_done),
    .frame_bit9(frame_bit9),
    .busy      (busy),
    .fifo_count(fifo_count)
);

// File: tb/rxu_serial_rx_tb_top.sv
module rxu_serial_rx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       baud_tick = 1'b0;
    logic       double_speed = 1'b0;
    logic [3:0] word_len = 4'd8;
    logic       parity_en = 1'b0;
    logic       parity_odd = 1'b0;
    logic       mp_mode = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, err_frame, err_parity, err_overrun, rx_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    rxu_serial_rx dut_i (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .baud_tick(baud_tick),
        .double_speed(double_speed), .word_len(word_len), .parity_en(parity_en),
        .parity_odd(parity_odd), .mp_mode(mp_mode), .rd_strobe(rd_strobe),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .err_frame(err_frame),
        .err_parity(err_parity), .err_overrun(err_overrun), .rx_valid(rx_valid)
    );

    // tick one cycle in four
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    typedef struct packed {
        logic [3:0] len;
        logic       ds, pen, podd, flip, stop0, epe, efe;
        logic [8:0] data;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{4'd8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0A5},
        '{4'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1FF},
        '{4'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h055},
        '{4'd9, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1C3},
        '{4'd8, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 9'h03C},
        '{4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 9'h02A},
        '{4'd9, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 9'h133},
        '{4'd8, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v, input int clks, input int glitch_at);
        rx_line = v;
        if (glitch_at > 0) begin
            repeat (glitch_at) @(negedge clk);
            rx_line = ~v;
            repeat (4) @(negedge clk);
            rx_line = v;
            repeat (clks - glitch_at - 4) @(negedge clk);
        end else begin
            repeat (clks) @(negedge clk);
        end
    endtask

    task automatic send_frame(input int len, input bit ds, input bit pen, input bit podd,
                              input logic [8:0] data, input bit flip, input bit stop0,
                              input int nstop, input int glitch_bit);
        int bclk;
        logic [8:0] m;
        bclk = ds ? 32 : 64;
        m = data & ((9'h1 << len) - 9'h1);
        double_speed = ds;
        word_len     = 4'(len);
        parity_en    = pen;
        parity_odd   = podd;
        drive_bit(1'b0, bclk, 0);
        for (int i = 0; i < len; i++)
            drive_bit(m[i], bclk, (i == glitch_bit) ? bclk / 2 + 1 : 0);
        if (pen) drive_bit((^m) ^ podd ^ flip, bclk, 0);
        drive_bit(!stop0, bclk, 0);
        for (int s = 1; s < nstop; s++) drive_bit(1'b1, bclk, 0);
    endtask

    task automatic idle_bits(input int n);
        rx_line = 1'b1;
        repeat (n * 64) @(negedge clk);
    endtask

    task automatic read_one;
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_head(input string req, input logic [7:0] d8, input logic b9,
                              input logic pe, input logic fe, input logic dor);
        check({req, " valid"},   32'(rx_valid),    32'd1);
        check({req, " data"},    32'(rx_data),     32'(d8));
        check({req, " bit9"},    32'(rx_bit9),     32'(b9));
        check({req, " parity"},  32'(err_parity),  32'(pe));
        check({req, " frame"},   32'(err_frame),   32'(fe));
        check({req, " overrun"}, 32'(err_overrun), 32'(dor));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: empty after reset
        check("R10 valid", 32'(rx_valid), 32'd0);
        check("R10 flags", 32'({err_frame, err_parity, err_overrun}), 32'd0);
        check("R10 data", 32'(rx_data), 32'd0);

        // R1 R2 R4 R5 R8: table of formats
        for (int i = 0; i < 8; i++) begin
            vec_t v;
            logic [8:0] m;
            v = VEC[i];
            m = v.data & ((9'h1 << v.len) - 9'h1);
            send_frame(int'(v.len), v.ds, v.pen, v.podd, v.data, v.flip, v.stop0, 1, -1);
            idle_bits(2);
            check_head($sformatf("R1 R4 R5 R8 vec%0d", i), m[7:0],
                       (v.len == 4'd9) ? m[8] : 1'b0, v.epe, v.efe, 1'b0);
            read_one();
            check($sformatf("R6 vec%0d drained", i), 32'(rx_valid), 32'd0);
        end

        // R2: one corrupted centre sample, both rates
        send_frame(8, 1'b0, 1'b0, 1'b0, 9'h0F, 1'b0, 1'b0, 1, 3);
        idle_bits(2);
        check_head("R2 glitch normal", 8'h0F, 1'b0, 1'b0, 1'b0, 1'b0);
        read_one();
        send_frame(8, 1'b1, 1'b0, 1'b0, 9'hF0, 1'b0, 1'b0, 1, 4);
        idle_bits(2);
        check_head("R2 glitch fast", 8'hF0, 1'b0, 1'b0, 1'b0, 1'b0);
        read_one();

        // R1: out-of-range length clamps
        send_frame(5, 1'b0, 1'b0, 1'b0, 9'h15, 1'b0, 1'b0, 1, -1);
        word_len = 4'd2;
        idle_bits(1);
        read_one();
        double_speed = 1'b0; parity_en = 1'b0;
        word_len = 4'd2;
        rx_line = 1'b0; repeat (64) @(negedge clk);
        for (int i = 0; i < 5; i++) begin rx_line = (i == 0 || i == 4); repeat (64) @(negedge clk); end
        rx_line = 1'b1; repeat (64) @(negedge clk);
        idle_bits(2);
        check_head("R1 clamp low", 8'h11, 1'b0, 1'b0, 1'b0, 1'b0);
        read_one();

        // R3: short low pulse is rejected
        word_len = 4'd8;
        rx_line = 1'b0;
        repeat (12) @(negedge clk);
        idle_bits(3);
        check("R3 false start", 32'(rx_valid), 32'd0);

        // R6: read of an empty buffer has no effect
        read_one();
        check("R6 empty read", 32'(rx_valid), 32'd0);

        // R5: two stop bits, frames back to back
        send_frame(8, 1'b0, 1'b1, 1'b0, 9'h81, 1'b0, 1'b0, 2, -1);
        send_frame(8, 1'b0, 1'b1, 1'b0, 9'h7E, 1'b0, 1'b0, 2, -1);
        idle_bits(2);
        check_head("R5 R6 first", 8'h81, 1'b0, 1'b0, 1'b0, 1'b0);
        read_one();
        check_head("R5 R6 second", 8'h7E, 1'b0, 1'b0, 1'b0, 1'b0);
        read_one();

        // R7 R8: overrun on third unread frame
        send_frame(8, 1'b0, 1'b0, 1'b0, 9'h11, 1'b0, 1'b0, 1, -1); idle_bits(1);
        send_frame(8, 1'b0, 1'b0, 1'b0, 9'h22, 1'b0, 1'b0, 1, -1); idle_bits(1);
        send_frame(8, 1'b0, 1'b0, 1'b0, 9'h33, 1'b0, 1'b0, 1, -1); idle_bits(2);
        check_head("R7 R8 oldest", 8'h11, 1'b0, 1'b0, 1'b0, 1'b0);
        read_one();
        check_head("R7 newest flagged", 8'h22, 1'b0, 1'b0, 1'b0, 1'b1);
        read_one();
        check("R7 dropped frame", 32'(rx_valid), 32'd0);

        // R9: address filter
        mp_mode = 1'b1;
        send_frame(9, 1'b0, 1'b0, 1'b0, 9'h0AB, 1'b0, 1'b0, 1, -1); idle_bits(2);
        check("R9 data frame skipped", 32'(rx_valid), 32'd0);
        send_frame(9, 1'b0, 1'b0, 1'b0, 9'h1CD, 1'b0, 1'b0, 1, -1); idle_bits(2);
        check_head("R9 address kept", 8'hCD, 1'b1, 1'b0, 1'b0, 1'b0);
        read_one();
        send_frame(8, 1'b0, 1'b0, 1'b0, 9'h05A, 1'b0, 1'b0, 1, -1); idle_bits(2);
        check_head("R9 short frame kept", 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0);
        read_one();
        mp_mode = 1'b0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule